// File: doc/BRIEF.md
# Cartridge Pin Steering Multiplexer

This block sits in the small programmable-logic device on an add-on cartridge. It decides where a group of shared host pins goes. The host drives two mode-select lines, and the block routes the host's clock, command, chip-select and data pins to one of three places. The first is the SD card socket. The second is a serial transmit/receive pair, with the transmit data carried on the flash card's command-latch-enable line. The third is an internal SPI register whose bits drive general-purpose expansion outputs. The flash card's command-latch line passes straight through in every mode except serial.

The select lines pass through a two-flop synchronizer before the block acts on them. Weak pull-ups on both select lines yield code 11, which is SD pass-through, so the cartridge behaves as an SD adapter until the host chooses otherwise.

In register mode the host runs SPI mode 0 transfers over the SD pins. The block oversamples those pins with its own clock. An 8-bit word written MSB first lands in a holding register and is copied to the output latches when chip select rises. During the same transfer, the old latch contents shift back out to the host.

Top module: `cart_pin_steer`

## Requirements
- R1: The mode code on `mode_sel_i` is decoded as follows: 11 is SD pass-through, 01 is serial, 10 is register mode, and 00 behaves exactly like 11. After reset the block is in SD pass-through whatever the select inputs are.
- R2: In SD pass-through mode:
  - `sd_clk_o` follows `host_clk_i`, `sd_cmd_o` follows `host_cmd_i`, `sd_cs_n_o` follows `host_cs_n_i`, and `host_dat_o` follows `sd_dat_i`.
  - At the same time, `flash_cle_o` follows `nand_cle_i`.
- R3: In serial mode:
  - `flash_cle_o` carries `host_cmd_i` (serial transmit) and ignores `nand_cle_i`.
  - `host_dat_o` carries `ser_rx_i`.
  - The socket is parked with `sd_clk_o`=0, `sd_cmd_o`=1 and `sd_cs_n_o`=1.
- R4: In register mode:
  - The socket is parked with `sd_clk_o`=0, `sd_cmd_o`=1 and `sd_cs_n_o`=1.
  - `flash_cle_o` follows `nand_cle_i`.
  - `host_dat_o` is the SPI MISO bit, which is 0 while no transfer is open.
- R5: In register mode, a transfer opens when `host_cs_n_i` falls. Bits on `host_cmd_i` are sampled MSB first at each rising `host_clk_i`. If exactly 8 bits were clocked when `host_cs_n_i` rises, `gpio_o` takes the new byte and holds it until the next such commit.
- R6: During a transfer, `host_dat_o` presents the previous `gpio_o` value MSB first. The first bit is valid after `host_cs_n_i` falls, and each following bit appears after a falling `host_clk_i`.
- R7: A transfer that ends with a bit count other than 8 (for example 7 or 9) leaves `gpio_o` unchanged.
- R8: A change of the synchronized mode code reaches the outputs within 4 clock cycles. Any change of mode aborts an open transfer, so a later chip-select rise commits nothing.
- R9: Outside register mode, activity on the host clock, command and chip-select pins never changes `gpio_o`.
- R10: Reset clears `gpio_o` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Host mode code (asynchronous) |
| host_clk_i | input | 1 | Host SD clock / SPI SCLK |
| host_cmd_i | input | 1 | Host SD command / SPI MOSI / serial transmit |
| host_cs_n_i | input | 1 | Host card select / SPI chip select, active low |
| host_dat_o | output | 1 | Data back to host: SD data, MISO or serial receive |
| sd_clk_o | output | 1 | Clock to SD socket |
| sd_cmd_o | output | 1 | Command to SD socket |
| sd_cs_n_o | output | 1 | Card select to SD socket |
| sd_dat_i | input | 1 | Data from SD socket |
| ser_rx_i | input | 1 | Serial receive line |
| nand_cle_i | input | 1 | Host flash command-latch-enable |
| flash_cle_o | output | 1 | Command-latch-enable to flash card, or serial transmit |
| gpio_o | output | GPIO_W | Expansion output latches |

## Verification
In SD and serial modes, the flash command-latch path and the SD or serial path can change in the same cycle. The random phase therefore toggles `nand_cle_i` and `host_cmd_i` together on every step. In serial mode it checks that `flash_cle_o` follows the transmit pin and not the flash input. In SD mode it checks that both paths pass through untouched. A directed case also lets a mode change fall in the middle of an open SPI transfer. It then judges that the later chip-select rise commits nothing to `gpio_o`.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [1:0] {
        ROUTE_SD  = 2'd0,
        ROUTE_SER = 2'd1,
        ROUTE_REG = 2'd2
    } route_e;

    function automatic route_e decode_sel(input logic [1:0] code);
        route_e r;
        case (code)
            2'b01:   r = ROUTE_SER;
            2'b10:   r = ROUTE_REG;
            default: r = ROUTE_SD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cps_mode_sync.sv
module cps_mode_sync
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    output route_e     route_o,
    output logic       change_o
);

    typedef struct packed {
        logic [1:0] meta;
        logic [1:0] sync;
        route_e     route;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.meta  = sel_i;
        st_d.sync  = st_q.meta;
        st_d.route = decode_sel(st_q.sync);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: 2'b11, sync: 2'b11, route: ROUTE_SD};
        end else begin
            st_q <= st_d;
        end
    end

    assign route_o  = st_q.route;
    assign change_o = (decode_sel(st_q.sync) != st_q.route);

    // R1: the reserved code lands on SD routing one cycle later
    assert_code00_sd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sync == 2'b00) |=> (route_o == ROUTE_SD));

    // R8: a pending change is applied on the next edge
    assert_change_applied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |=> (route_o != $past(route_o)));

endmodule

// File: rtl/cps_spi_reg.sv
module cps_spi_reg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              abort_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              csn_i,
    output logic [WORD_W-1:0] latch_o,
    output logic              miso_o
);

    localparam int CNT_W = $clog2(WORD_W) + 2;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam int PIN_CS   = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_MOSI = 0;

    typedef struct packed {
        logic [2:0]        meta;
        logic [2:0]        sync;
        logic [2:0]        prev;
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] shout;
        logic [WORD_W-1:0] latch;
    } state_t;

    state_t st_d, st_q;

    logic cs_fall, cs_rise, sck_rise, sck_fall;

    always_comb begin
        cs_fall  =  st_q.prev[PIN_CS]   & ~st_q.sync[PIN_CS];
        cs_rise  = ~st_q.prev[PIN_CS]   &  st_q.sync[PIN_CS];
        sck_rise = ~st_q.prev[PIN_SCLK] &  st_q.sync[PIN_SCLK];
        sck_fall =  st_q.prev[PIN_SCLK] & ~st_q.sync[PIN_SCLK];

        st_d      = st_q;
        st_d.meta = {csn_i, sclk_i, mosi_i};
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;

        if (!en_i || abort_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.shout  = st_q.latch;
        end else if (st_q.active) begin
            if (cs_rise) begin
                st_d.active = 1'b0;
                if (st_q.cnt == CNT_FULL) begin
                    st_d.latch = st_q.hold;
                end
            end else begin
                if (sck_rise) begin
                    st_d.hold = {st_q.hold[WORD_W-2:0], st_q.sync[PIN_MOSI]};
                    if (st_q.cnt != CNT_MAX) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                if (sck_fall) begin
                    st_d.shout = {st_q.shout[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: 3'b100, sync: 3'b100, prev: 3'b100, active: 1'b0,
                      cnt: '0, hold: '0, shout: '0, latch: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o = st_q.latch;
    assign miso_o  = st_q.active & st_q.shout[WORD_W-1];

    // R5: latches only move at the end of an open transfer
    assert_latch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |=> $stable(st_q.latch));

    // R8: a mode change closes any open transfer
    assert_abort_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !st_q.active);

    // R9: no transfer can be open outside register mode
    assert_no_xfer_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.active);

endmodule

// File: rtl/cps_router.sv
module cps_router
    import cps_pkg::*;
(
    input  route_e route_i,
    input  logic   host_clk_i,
    input  logic   host_cmd_i,
    input  logic   host_cs_n_i,
    input  logic   sd_dat_i,
    input  logic   ser_rx_i,
    input  logic   nand_cle_i,
    input  logic   miso_i,
    output logic   host_dat_o,
    output logic   sd_clk_o,
    output logic   sd_cmd_o,
    output logic   sd_cs_n_o,
    output logic   flash_cle_o
);

    always_comb begin
        sd_clk_o    = 1'b0;
        sd_cmd_o    = 1'b1;
        sd_cs_n_o   = 1'b1;
        host_dat_o  = 1'b0;
        flash_cle_o = nand_cle_i;
        case (route_i)
            ROUTE_SER: begin
                flash_cle_o = host_cmd_i;
                host_dat_o  = ser_rx_i;
            end
            ROUTE_REG: begin
                host_dat_o = miso_i;
            end
            default: begin
                sd_clk_o   = host_clk_i;
                sd_cmd_o   = host_cmd_i;
                sd_cs_n_o  = host_cs_n_i;
                host_dat_o = sd_dat_i;
            end
        endcase
    end

    // R4: the socket clock is silent in register mode
    always_comb begin
        if (route_i == ROUTE_REG) begin
            assert_sdclk_gated_R4: assert (sd_clk_o == 1'b0);
        end
    end

    // R3: the command-latch line carries serial transmit in serial mode
    always_comb begin
        if (route_i == ROUTE_SER) begin
            assert_cle_borrowed_R3: assert (flash_cle_o == host_cmd_i);
        end else begin
            assert_cle_restored_R2: assert (flash_cle_o == nand_cle_i);
        end
    end

endmodule

// File: rtl/cart_pin_steer.sv
module cart_pin_steer
    import cps_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel_i,
    input  logic              host_clk_i,
    input  logic              host_cmd_i,
    input  logic              host_cs_n_i,
    output logic              host_dat_o,
    output logic              sd_clk_o,
    output logic              sd_cmd_o,
    output logic              sd_cs_n_o,
    input  logic              sd_dat_i,
    input  logic              ser_rx_i,
    input  logic              nand_cle_i,
    output logic              flash_cle_o,
    output logic [GPIO_W-1:0] gpio_o
);

    route_e route;
    logic   mode_change;
    logic   miso;

    cps_mode_sync u_mode_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (mode_sel_i),
        .route_o  (route),
        .change_o (mode_change)
    );

    cps_spi_reg #(.WORD_W(GPIO_W)) u_spi_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (route == ROUTE_REG),
        .abort_i (mode_change),
        .sclk_i  (host_clk_i),
        .mosi_i  (host_cmd_i),
        .csn_i   (host_cs_n_i),
        .latch_o (gpio_o),
        .miso_o  (miso)
    );

    cps_router u_router (
        .route_i     (route),
        .host_clk_i  (host_clk_i),
        .host_cmd_i  (host_cmd_i),
        .host_cs_n_i (host_cs_n_i),
        .sd_dat_i    (sd_dat_i),
        .ser_rx_i    (ser_rx_i),
        .nand_cle_i  (nand_cle_i),
        .miso_i      (miso),
        .host_dat_o  (host_dat_o),
        .sd_clk_o    (sd_clk_o),
        .sd_cmd_o    (sd_cmd_o),
        .sd_cs_n_o   (sd_cs_n_o),
        .flash_cle_o (flash_cle_o)
    );

    // R10: the expansion pins start cleared
    assert_gpio_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (gpio_o == '0));

endmodule

// File: tb/cart_pin_steer_tb_top.sv
module cart_pin_steer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int GW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b11;
    logic hclk = 1'b0, hcmd = 1'b0, hcs = 1'b1, sddat = 1'b0, rx = 1'b0, cle = 1'b0;
    logic host_dat, sd_clk, sd_cmd, sd_cs_n, flash_cle;
    logic [GW-1:0] gpio;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [GW-1:0] exp_gpio = '0;
    logic [1:0] cur_code = 2'b11;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_pin_steer #(.GPIO_W(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel),
        .host_clk_i(hclk), .host_cmd_i(hcmd), .host_cs_n_i(hcs),
        .host_dat_o(host_dat), .sd_clk_o(sd_clk), .sd_cmd_o(sd_cmd),
        .sd_cs_n_o(sd_cs_n), .sd_dat_i(sddat), .ser_rx_i(rx),
        .nand_cle_i(cle), .flash_cle_o(flash_cle), .gpio_o(gpio)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {sd_clk, sd_cmd, sd_cs_n, host_dat, flash_cle} with no transfer open
    function automatic logic [4:0] exp_pins(input logic [1:0] code, input logic c,
        input logic m, input logic s, input logic d, input logic r, input logic l);
        case (code)
            2'b01:   return {1'b0, 1'b1, 1'b1, r, m};
            2'b10:   return {1'b0, 1'b1, 1'b1, 1'b0, l};
            default: return {c, m, s, d, l};
        endcase
    endfunction

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] code);
        mode_sel = code;
        cur_code = code;
        wait_neg(4);
    endtask

    task automatic check_pins(input string req);
        #1;
        check(req, {sd_clk, sd_cmd, sd_cs_n, host_dat, flash_cle},
              exp_pins(cur_code, hclk, hcmd, hcs, sddat, rx, cle));
    endtask

    task automatic spi_xfer(input logic [GW-1:0] wr, input int nbits, input bit close,
                            output logic [GW-1:0] rd);
        rd = '0;
        hcs = 1'b0;
        wait_neg(6);
        for (int i = 0; i < nbits; i++) begin
            hcmd = (i < GW) ? wr[GW-1-i] : 1'($urandom);
            wait_neg(4);
            #1;
            if (i < GW) rd[GW-1-i] = host_dat;
            wait_neg(2);
            hclk = 1'b1;
            wait_neg(6);
            hclk = 1'b0;
        end
        wait_neg(4);
        if (close) begin
            hcs = 1'b1;
            wait_neg(6);
        end
    endtask

    initial begin
        logic [GW-1:0] rd, wr;
        logic [1:0] codes [4];
        codes[0] = 2'b11; codes[1] = 2'b01; codes[2] = 2'b10; codes[3] = 2'b00;
        void'($urandom(32'h5EED_0042));

        wait_neg(3);
        // R10 / R1: reset state, SD routing even with another code on the pins
        mode_sel = 2'b10;
        #1;
        check("R10 gpio after reset", gpio, '0);
        check("R1 reset routes SD", {sd_clk, sd_cmd, sd_cs_n, host_dat, flash_cle},
              exp_pins(2'b11, hclk, hcmd, hcs, sddat, rx, cle));
        rst_n = 1'b1;
        set_mode(2'b11);

        // R2 R3 R4 R1: random routing, flash and host lines toggled in the same cycle
        for (int k = 0; k < 24; k++) begin
            set_mode(codes[$urandom % 4]);
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                hclk = 1'($urandom); hcmd = 1'($urandom); sddat = 1'($urandom);
                rx = 1'($urandom); cle = 1'($urandom);
                hcs = (cur_code == 2'b10) ? 1'b1 : 1'($urandom);
                case (cur_code)
                    2'b01:   check_pins("R3 serial routing");
                    2'b10:   check_pins("R4 register routing");
                    2'b00:   check_pins("R1 code 00 as SD");
                    default: check_pins("R2 SD routing with flash");
                endcase
            end
            hclk = 1'b0; hcs = 1'b1;
            wait_neg(4);
            check("R9 gpio untouched by routing traffic", gpio, exp_gpio);
        end

        // R5 R6: full writes with readback of the previous value
        set_mode(2'b10);
        check("R8 mode applied", {sd_clk, sd_cmd, sd_cs_n}, 3'b011);
        for (int k = 0; k < 10; k++) begin
            wr = (k == 0) ? 8'hA5 : (k == 1) ? 8'hFF : (k == 2) ? 8'h00 : 8'($urandom);
            spi_xfer(wr, GW, 1'b1, rd);
            check("R6 readback of previous latch", rd, exp_gpio);
            exp_gpio = wr;
            check("R5 latched write", gpio, exp_gpio);
        end

        // R7: short and long transfers change nothing
        spi_xfer(8'h3C, GW - 1, 1'b1, rd);
        check("R7 seven-bit transfer ignored", gpio, exp_gpio);
        check("R6 readback on short transfer", rd[GW-1:1], exp_gpio[GW-1:1]);
        spi_xfer(8'hC3, GW + 1, 1'b1, rd);
        check("R7 nine-bit transfer ignored", gpio, exp_gpio);

        // R8: mode change while a full transfer is open
        spi_xfer(~exp_gpio, GW, 1'b0, rd);
        set_mode(2'b11);
        set_mode(2'b10);
        hcs = 1'b1;
        wait_neg(6);
        check("R8 aborted transfer commits nothing", gpio, exp_gpio);
        spi_xfer(8'h5A, GW, 1'b1, rd);
        check("R8 next transfer after abort reads latch", rd, exp_gpio);
        exp_gpio = 8'h5A;
        check("R5 write after abort", gpio, exp_gpio);

        // R9: SPI-shaped traffic in SD and serial modes is not a write
        set_mode(2'b11);
        spi_xfer(8'h81, GW, 1'b1, rd);
        check("R9 SD-mode traffic ignored", gpio, exp_gpio);
        set_mode(2'b01);
        spi_xfer(8'h18, GW, 1'b1, rd);
        check("R9 serial-mode traffic ignored", gpio, exp_gpio);
        set_mode(2'b00);
        spi_xfer(8'h66, GW, 1'b1, rd);
        check("R9 code-00 traffic ignored", gpio, exp_gpio);

        // R10: reset again clears latches
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 gpio cleared by reset", gpio, '0);
        wait_neg(2);
        rst_n = 1'b1;
        wait_neg(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule